// File: doc/BRIEF.md
# Camera Serial Link Bring-Up Sequencer

This block brings up the receive side of a camera serial link after power-on. When a start request arrives it writes the lane count, releases the PHY shutdown, the PHY reset and the controller reset, and then checks three link conditions in a fixed order. First it checks that the clock lane has left its ultra-low-power state. Next it checks that the error status reads clean. Last it checks that the clock lane runs in high-speed mode. Each check is polled only on an external interval tick, so the pacing (about 10 to 20 ms in a system) is set outside the block.

Each stage has a bounded number of polls. If a stage is still not met on its last poll, the block stops with an error flag and a code that names the failed stage. If all three stages pass, a ready flag rises and holds. A stop request, from any state, drops all enable controls and returns the block to idle.

Top module: `dphy_link_monitor`

## Requirements
- R1: After reset, all enable outputs, `lane_cfg_o`, `ready_o`, `error_o`, `fail_code_o` and `stage_o` are 0.
- R2: A start pulse in idle sets all three enable outputs to 1 on the next cycle. In that same cycle `lane_cfg_o` takes the lane count sampled with the start minus one, and `stage_o` becomes 1.
- R3: In stage 1, a tick passes the stage when `phy_status_i` is not exactly 0x200. Any other value, including 0x201 or 0x000, passes. A pass moves `stage_o` to 2.
- R4: In stage 2, a tick passes the stage when `err_status_i` is zero, and `stage_o` moves to 3.
- R5: In stage 3, a tick passes the stage when bit 8 of `phy_status_i` is 1. On the next cycle `ready_o` is 1 and `stage_o` is 0.
- R6: A stage is evaluated only in a cycle where `tick_i` is 1. Without a tick the stage does not advance, whatever the status inputs show.
- R7: Each stage allows at most MAX_POLLS (default 50) failing polls. The failing poll numbered MAX_POLLS sets `error_o` to 1, sets `fail_code_o` to the stage number (1, 2 or 3) and sets `stage_o` to 0. The enable outputs stay at 1, and the poll before that one leaves the stage still running.
- R8: `ready_o` and `error_o` hold until a stop request. A start pulse outside idle has no effect.
- R9: A stop pulse in any state clears the enable outputs, `ready_o`, `error_o` and `fail_code_o` on the next cycle and returns the block to idle. Stop wins over a start pulse or a passing tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start bring-up (acts in idle only) |
| stop_i | input | 1 | Disable request, any state |
| tick_i | input | 1 | Poll interval strobe |
| lanes_i | input | LANE_W | Number of data lanes |
| phy_status_i | input | STAT_W | PHY status word |
| err_status_i | input | STAT_W | Error status word |
| shutdown_rel_o | output | 1 | PHY shutdown release |
| phy_rst_rel_o | output | 1 | PHY reset release |
| ctrl_rst_rel_o | output | 1 | Controller reset release |
| lane_cfg_o | output | LANE_W | Lane count minus one |
| ready_o | output | 1 | Link up |
| error_o | output | 1 | Stage timed out |
| fail_code_o | output | 2 | Failed stage, 1 to 3 |
| stage_o | output | 2 | Stage being polled, 0 when none |

## Verification
A stop request can arrive in the same cycle as a tick on which the stage condition holds. The bench provokes this in stage 3 with bit 8 of the PHY status set. It judges the result by `ready_o` staying 0 and every enable output reading 0 on the next cycle. Stop and start are also raised together in idle, and the bench expects the block to stay in idle. The bench also lands a passing tick on the last allowed poll of a stage, where it must see a pass and no timeout.

// File: rtl/dphy_link_monitor.sv
module dphy_link_monitor #(
  parameter int STAT_W    = 32,
  parameter int LANE_W    = 3,
  parameter int MAX_POLLS = 50,
  parameter int HS_BIT    = 8,
  parameter logic [STAT_W-1:0] ULP_WORD = STAT_W'(32'h200)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic [LANE_W-1:0] lanes_i,
  input  logic [STAT_W-1:0] phy_status_i,
  input  logic [STAT_W-1:0] err_status_i,
  output logic              shutdown_rel_o,
  output logic              phy_rst_rel_o,
  output logic              ctrl_rst_rel_o,
  output logic [LANE_W-1:0] lane_cfg_o,
  output logic              ready_o,
  output logic              error_o,
  output logic [1:0]        fail_code_o,
  output logic [1:0]        stage_o
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ULP, S_ERR, S_HS, S_READY, S_FAIL} state_t;

  state_t            state;
  logic [CNT_W-1:0]  polls;
  logic              en_q;
  logic              met;
  logic              polling;

  assign polling = (state == S_ULP) || (state == S_ERR) || (state == S_HS);

  always_comb begin
    case (state)
      S_ULP:   met = (phy_status_i != ULP_WORD);
      S_ERR:   met = (err_status_i == '0);
      S_HS:    met = phy_status_i[HS_BIT];
      default: met = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      polls       <= '0;
      en_q        <= 1'b0;
      lane_cfg_o  <= '0;
      fail_code_o <= 2'd0;
    end else if (stop_i) begin
      state       <= S_IDLE;
      polls       <= '0;
      en_q        <= 1'b0;
      lane_cfg_o  <= '0;
      fail_code_o <= 2'd0;
    end else if (state == S_IDLE) begin
      if (start_i) begin
        state      <= S_ULP;
        polls      <= '0;
        en_q       <= 1'b1;
        lane_cfg_o <= lanes_i - LANE_W'(1);
      end
    end else if (polling && tick_i) begin
      if (met) begin
        polls <= '0;
        case (state)
          S_ULP:   state <= S_ERR;
          S_ERR:   state <= S_HS;
          default: state <= S_READY;
        endcase
      end else if (polls == LAST) begin
        polls       <= '0;
        fail_code_o <= stage_o;
        state       <= S_FAIL;
      end else begin
        polls <= polls + CNT_W'(1);
      end
    end
  end

  assign shutdown_rel_o = en_q;
  assign phy_rst_rel_o  = en_q;
  assign ctrl_rst_rel_o = en_q;
  assign ready_o        = (state == S_READY);
  assign error_o        = (state == S_FAIL);
  assign stage_o        = (state == S_ULP) ? 2'd1 :
                          (state == S_ERR) ? 2'd2 :
                          (state == S_HS)  ? 2'd3 : 2'd0;

  p_lane_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_i && !stop_i) |=>
      (en_q && stage_o == 2'd1 && lane_cfg_o == $past(lanes_i) - LANE_W'(1)));

  p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (polling && !tick_i && !stop_i) |=> $stable(stage_o) && !ready_o && !error_o);

  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    polls < CNT_W'(MAX_POLLS));

  p_fail_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (fail_code_o != 2'd0 && en_q));

  p_ready_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !stop_i) |=> ready_o);

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!shutdown_rel_o && !ready_o && !error_o && stage_o == 2'd0));

  always_comb begin
    if (rst_n) p_flags_excl_r8: assert (!(ready_o && error_o));
  end
endmodule

// File: tb/dphy_link_monitor_bench.sv
module dphy_link_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, tick_i = 1'b0;
  logic [2:0]  lanes_i = 3'd0;
  logic [31:0] phy_status_i = 32'h200, err_status_i = 32'h0;
  logic sd, pr, cr, rdy, err;
  logic [2:0] lcfg;
  logic [1:0] code, stg;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dphy_link_monitor u_dphy_link_monitor (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .tick_i(tick_i),
    .lanes_i(lanes_i), .phy_status_i(phy_status_i), .err_status_i(err_status_i),
    .shutdown_rel_o(sd), .phy_rst_rel_o(pr), .ctrl_rst_rel_o(cr), .lane_cfg_o(lcfg),
    .ready_o(rdy), .error_o(err), .fail_code_o(code), .stage_o(stg));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask
  task automatic pulse_stop();
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
  endtask
  task automatic poll(input logic [31:0] phy, input logic [31:0] es);
    phy_status_i = phy; err_status_i = es; tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask
  task automatic enables(input string req, input logic v);
    chk(req, {29'd0, sd, pr, cr}, v ? 32'd7 : 32'd0);
  endtask

  task automatic t_reset();
    enables("R1 enables", 1'b0);
    chk("R1 lane", 32'(lcfg), 0); chk("R1 ready", 32'(rdy), 0);
    chk("R1 error", 32'(err), 0); chk("R1 code", 32'(code), 0); chk("R1 stage", 32'(stg), 0);
  endtask

  task automatic t_bringup(input logic [2:0] lanes);
    lanes_i = lanes; pulse_start(); lanes_i = 3'd7;
    enables("R2 enables", 1'b1);
    chk("R2 lane", 32'(lcfg), 32'(lanes - 3'd1)); chk("R2 stage", 32'(stg), 1);
    poll(32'h200, 0); chk("R3 ulp held", 32'(stg), 1);
    phy_status_i = 32'h001; repeat (3) @(negedge clk);
    chk("R6 no tick", 32'(stg), 1);
    poll(32'h201, 0); chk("R3 pass", 32'(stg), 2);
    poll(32'h100, 32'h4); chk("R4 held", 32'(stg), 2);
    poll(32'h100, 0); chk("R4 pass", 32'(stg), 3);
    poll(32'h0FF, 0); chk("R5 held", 32'(stg), 3); chk("R5 not ready", 32'(rdy), 0);
    poll(32'h100, 0); chk("R5 ready", 32'(rdy), 1); chk("R5 stage", 32'(stg), 0);
    pulse_start(); repeat (2) @(negedge clk);
    chk("R8 ready holds", 32'(rdy), 1); chk("R8 lane kept", 32'(lcfg), 32'(lanes - 3'd1));
    pulse_stop(); t_reset_after_stop();
  endtask

  task automatic t_reset_after_stop();
    enables("R9 enables", 1'b0);
    chk("R9 ready", 32'(rdy), 0); chk("R9 error", 32'(err), 0);
    chk("R9 code", 32'(code), 0); chk("R9 stage", 32'(stg), 0);
  endtask

  task automatic t_timeout(input int stage);
    logic [31:0] bad_phy, bad_err;
    lanes_i = 3'd2; pulse_start();
    if (stage > 1) poll(32'h001, 0);
    if (stage > 2) poll(32'h001, 0);
    bad_phy = (stage == 1) ? 32'h200 : 32'h001;
    bad_err = (stage == 2) ? 32'h1 : 32'h0;
    for (int i = 0; i < 49; i++) poll(bad_phy, bad_err);
    chk("R7 not yet", 32'(err), 0); chk("R7 still polling", 32'(stg), 32'(stage));
    poll(bad_phy, bad_err);
    chk("R7 error", 32'(err), 1); chk("R7 code", 32'(code), 32'(stage));
    chk("R7 stage", 32'(stg), 0); enables("R7 enables kept", 1'b1);
    pulse_start(); poll(32'h100, 0);
    chk("R8 error holds", 32'(err), 1); chk("R8 no ready", 32'(rdy), 0);
    pulse_stop(); t_reset_after_stop();
  endtask

  task automatic t_last_poll_pass();
    lanes_i = 3'd4; pulse_start();
    for (int i = 0; i < 49; i++) poll(32'h200, 0);
    poll(32'h000, 0);
    chk("R3 pass on last poll", 32'(stg), 2); chk("R7 no timeout", 32'(err), 0);
    pulse_stop();
  endtask

  task automatic t_clash();
    lanes_i = 3'd1; pulse_start();
    chk("R2 one lane", 32'(lcfg), 0);
    poll(32'h001, 0); poll(32'h001, 0);
    phy_status_i = 32'h100; tick_i = 1'b1; stop_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; stop_i = 1'b0;
    chk("R9 stop beats pass", 32'(rdy), 0); t_reset_after_stop();
    start_i = 1'b1; stop_i = 1'b1; @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
    chk("R9 stop beats start", 32'(stg), 0); enables("R9 idle enables", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; @(negedge clk);
    t_bringup(3'd4);
    t_timeout(1); t_timeout(2); t_timeout(3);
    t_last_poll_pass();
    t_clash();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule